// File: doc/BRIEF.md
# Dual Up-Counter Timer Peripheral

This peripheral holds two free-running up-counters behind a byte-wide register bus: an 8-bit timer 0 and a 16-bit timer 1. Software loads a start value and sets an enable bit. Each counter then counts up by one on every selected count event. Past the all-ones value it wraps back to its stored start value and raises a one-cycle interrupt pulse. A count event is one of three things: every system clock cycle, a chosen edge of a slow reference clock, or, for timer 1 only, a chosen edge of an external pin. Both asynchronous clock inputs pass through a two-flop synchronizer before edge detection.

Timer 1 moves 16 bits through an 8-bit bus by way of a shared low-byte holding register. Software writes the low byte into the holding register first. A write of the high byte then commits both halves to the counter at once. A read of the high byte copies the live low byte into the holding register, so the next low read returns the value that belongs with that high byte.

Top module: `dual_timer_periph`

## Requirements
- R1: After reset the control register (address 0x7) reads 0x00 and both interrupts are low. The register addresses are 0x7 control, 0x8 timer 1 low holding register, 0x9 timer 1 high, 0xA timer 0. Read data is combinational from addr_i in the same cycle, and unmapped addresses read 0x00.
- R2: Control bits: 0 timer 0 enable, 1 timer 1 enable, 2 timer 0 edge (0 rising, 1 falling), 3 timer 1 edge, 4 timer 0 source (0 reference clock, 1 system clock), 5 timer 1 source, 6 reserved (reads 0), 7 timer 1 external mode.
- R3: With the system clock selected and the enable set, a counter advances by one on every clock edge after the edge that writes the enable.
- R4: With the reference clock selected, a counter advances once per selected edge of ref_clk_i and ignores the other edge. The step appears on the third rising clk_i edge after the input changes.
- R5: In timer 1 external mode, timer 1 advances on the selected edge of ext_clk_i only. Bit 5 and ref_clk_i have no effect.
- R6: Clearing an enable holds the counter value. Setting it again resumes counting from the held value.
- R7: A count from the all-ones value reloads the stored start value and drives that timer's interrupt high for exactly one cycle.
- R8: A timer 0 write sets both the start value and the counter. It overrides a count in the same cycle, and that count raises no interrupt.
- R9: A timer 1 low write changes only the holding register and leaves the counter unchanged.
- R10: A timer 1 high write loads the counter and start value with {written byte, holding register}.
- R11: A timer 1 high read returns the counter's high byte and, at that clock edge, copies the counter's low byte into the holding register. A low read returns the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (acts on timer 1 high reads) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous |
| ext_clk_i | input | 1 | Timer 1 external count input, asynchronous |
| irq_t0_o | output | 1 | Timer 0 overflow pulse |
| irq_t1_o | output | 1 | Timer 1 overflow pulse |

## Verification
The assertions assume that wr_en_i and rd_en_i are never high in the same cycle. They also assume that rd_en_i and wr_en_i change only between clock edges. The stimulus follows both rules: one task issues every bus access on the falling clock edge and holds a single strobe for one cycle. The reference and external inputs are held for six clock cycles per level, well above the synchronizer depth, so no edge is lost. Start values are kept below the all-ones value, so an interrupt never fires in two consecutive cycles.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h7;
  localparam logic [ADDR_W-1:0] A_T1_LO = 4'h8;
  localparam logic [ADDR_W-1:0] A_T1_HI = 4'h9;
  localparam logic [ADDR_W-1:0] A_T0    = 4'hA;

  typedef struct packed {
    logic t1_ext;
    logic rsvd;
    logic t1_sys;
    logic t0_sys;
    logic t1_fall;
    logic t0_fall;
    logic t1_en;
    logic t0_en;
  } ctrl_t;

  localparam logic [7:0] CTRL_WMASK = 8'hBF;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  // sh_q[STAGES] is the previous synchronized sample
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/up_counter.sv
module up_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] pre_q, cnt_q;
  logic         ovf_q;
  logic         wrap;

  assign wrap = tick_i & (cnt_q == ALL_ONES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap & ~load_i;
      if (load_i) begin
        pre_q <= load_val_i;
        cnt_q <= load_val_i;
      end else if (wrap) begin
        cnt_q <= pre_q;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/dual_timer_periph.sv
module dual_timer_periph
  import dtmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ref_clk_i,
  input  logic              ext_clk_i,
  output logic              irq_t0_o,
  output logic              irq_t1_o
);
  localparam int T0_W = DATA_W;
  localparam int T1_W = 2 * DATA_W;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] lo_buf_q;
  logic [T0_W-1:0]   cnt0;
  logic [T1_W-1:0]   cnt1;
  logic ref_rise, ref_fall, ext_rise, ext_fall;
  logic tick0, tick1, ref_edge0, ref_edge1, ext_edge1;
  logic wr_ctrl, wr_lo, wr_hi, wr_t0, rd_hi;

  assign wr_ctrl = wr_en_i & (addr_i == A_CTRL);
  assign wr_lo   = wr_en_i & (addr_i == A_T1_LO);
  assign wr_hi   = wr_en_i & (addr_i == A_T1_HI);
  assign wr_t0   = wr_en_i & (addr_i == A_T0);
  assign rd_hi   = rd_en_i & (addr_i == A_T1_HI);

  edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ref_clk_i),
    .rise_o(ref_rise), .fall_o(ref_fall));

  edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ext_clk_i),
    .rise_o(ext_rise), .fall_o(ext_fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i & CTRL_WMASK);
  end

  // write to the holding register wins over a snapshot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lo_buf_q <= '0;
    else if (wr_lo) lo_buf_q <= wdata_i;
    else if (rd_hi) lo_buf_q <= cnt1[DATA_W-1:0];
  end

  assign ref_edge0 = ctrl_q.t0_fall ? ref_fall : ref_rise;
  assign ref_edge1 = ctrl_q.t1_fall ? ref_fall : ref_rise;
  assign ext_edge1 = ctrl_q.t1_fall ? ext_fall : ext_rise;

  assign tick0 = ctrl_q.t0_en & (ctrl_q.t0_sys | ref_edge0);
  assign tick1 = ctrl_q.t1_en &
                 (ctrl_q.t1_ext ? ext_edge1 : (ctrl_q.t1_sys | ref_edge1));

  up_counter #(.W(T0_W)) u_t0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_t0), .load_val_i(wdata_i),
    .tick_i(tick0), .cnt_o(cnt0), .ovf_o(irq_t0_o));

  up_counter #(.W(T1_W)) u_t1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_hi),
    .load_val_i({wdata_i, lo_buf_q}),
    .tick_i(tick1), .cnt_o(cnt1), .ovf_o(irq_t1_o));

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_T1_LO: rdata_o = lo_buf_q;
      A_T1_HI: rdata_o = cnt1[T1_W-1:DATA_W];
      A_T0:    rdata_o = cnt0;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_timer_periph_chk.sv
module dual_timer_periph_chk
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                irq_t0_o,
  input logic                irq_t1_o,
  input logic                t0_en,
  input logic                tick1,
  input logic [DATA_W-1:0]   cnt0,
  input logic [2*DATA_W-1:0] cnt1,
  input logic [DATA_W-1:0]   lo_buf
);
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL) |-> (rdata_o[6] == 1'b0)); // R2

  AST_T0_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!t0_en && !(wr_en_i && addr_i == A_T0)) |=> $stable(cnt0)); // R6

  AST_T0_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_T0) |=> (cnt0 == $past(wdata_i) && !irq_t0_o)); // R8

  AST_T1_LO_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_T1_LO && !tick1) |=> $stable(cnt1)); // R9

  AST_T1_HI_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_T1_HI) |=> (cnt1 == {$past(wdata_i), $past(lo_buf)})); // R10

  AST_T1_HI_SNAPSHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == A_T1_HI) |=> (lo_buf == $past(cnt1[DATA_W-1:0]))); // R11

  AST_IRQ0_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_t0_o |=> !irq_t0_o); // R7

  AST_IRQ1_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_t1_o |-> ($past(cnt1) == '1)); // R7
endmodule

bind dual_timer_periph dual_timer_periph_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .irq_t0_o(irq_t0_o), .irq_t1_o(irq_t1_o), .t0_en(ctrl_q.t0_en),
  .tick1(tick1), .cnt0(cnt0), .cnt1(cnt1), .lo_buf(lo_buf_q));

// File: tb/tb_dual_timer_periph.sv
`timescale 1ns/1ps
module tb_dual_timer_periph;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ref_clk_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       irq_t0_o, irq_t1_o;

  int n_chk = 0, n_fail = 0, irq0_seen = 0, irq1_seen = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dual_timer_periph dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ref_clk_i(ref_clk_i), .ext_clk_i(ext_clk_i),
    .irq_t0_o(irq_t0_o), .irq_t1_o(irq_t1_o));

  always @(negedge clk_i) begin
    if (irq_t0_o) irq0_seen++;
    if (irq_t1_o) irq1_seen++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all bus tasks are entered at a falling edge and return at the next one
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic rd_t1(output logic [15:0] v);
    logic [7:0] h, l;
    rd(4'h9, h);
    rd(4'h8, l);
    v = {h, l};
  endtask

  task automatic load_t1(input logic [15:0] v);
    wr(4'h8, v[7:0]);
    wr(4'h9, v[15:8]);
  endtask

  // enable with ctrl value, wait n cycles, disable: n+1 system-clock steps
  task automatic run_sys(input logic [7:0] c, input int n);
    wr(4'h7, c);
    repeat (n) @(negedge clk_i);
    wr(4'h7, 8'h00);
  endtask

  task automatic pulse(ref logic sig, input int periods);
    for (int i = 0; i < periods; i++) begin
      sig = 1'b1; repeat (6) @(negedge clk_i);
      sig = 1'b0; repeat (6) @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(4'h7, d);  check("R1 ctrl after reset", d, 8'h00);
    check("R1 irq0 after reset", irq_t0_o, 0);
    check("R1 irq1 after reset", irq_t1_o, 0);
    rd(4'h3, d);  check("R1 unmapped read", d, 8'h00);
    wr(4'h7, 8'hFF);
    rd(4'h7, d);  check("R2 reserved bit reads 0", d, 8'hBF);
    wr(4'h7, 8'h00);
  endtask

  task automatic t_t0_sys;
    logic [7:0] d;
    wr(4'hA, 8'h10);
    rd(4'hA, d);  check("R8 t0 load", d, 8'h10);
    run_sys(8'h11, 5);
    rd(4'hA, d);  check("R3 t0 system clock count", d, 8'h16);
  endtask

  task automatic t_t0_ovf;
    logic [7:0] d;
    int b;
    wr(4'hA, 8'hFD);
    b = irq0_seen;
    run_sys(8'h11, 4);
    repeat (2) @(negedge clk_i);
    rd(4'hA, d);  check("R7 t0 reload value", d, 8'hFF);
    check("R7 t0 irq one cycle", irq0_seen - b, 1);
  endtask

  task automatic t_freeze;
    logic [7:0] d;
    wr(4'hA, 8'h20);
    run_sys(8'h11, 2);
    repeat (10) @(negedge clk_i);
    rd(4'hA, d);  check("R6 held while disabled", d, 8'h23);
    run_sys(8'h11, 0);
    rd(4'hA, d);  check("R6 resume from held", d, 8'h24);
  endtask

  task automatic t_t0_priority;
    logic [7:0] d;
    int b;
    wr(4'hA, 8'hFF);
    b = irq0_seen;
    wr(4'h7, 8'h11);
    wr(4'hA, 8'h40);        // lands on the wrapping count
    rd(4'hA, d);  check("R8 write wins over count", d, 8'h40);
    wr(4'h7, 8'h00);
    repeat (2) @(negedge clk_i);
    check("R8 no irq on overridden wrap", irq0_seen - b, 0);
  endtask

  task automatic t_t1_buffer;
    logic [7:0] d;
    logic [15:0] v;
    load_t1(16'hABCD);
    wr(4'h8, 8'h34);
    rd(4'h8, d);  check("R11 low read returns holding reg", d, 8'h34);
    rd_t1(v);     check("R9 low write leaves counter", v, 16'hABCD);
    wr(4'h8, 8'h34);
    wr(4'h9, 8'h12);
    rd_t1(v);     check("R10 high write commits pair", v, 16'h1234);
  endtask

  task automatic t_t1_count;
    logic [15:0] v;
    int b;
    load_t1(16'h00FE);
    run_sys(8'h22, 2);
    rd_t1(v);     check("R3 t1 carry into high byte", v, 16'h0101);
    load_t1(16'hFFFE);
    b = irq1_seen;
    run_sys(8'h22, 1);
    repeat (2) @(negedge clk_i);
    rd_t1(v);     check("R7 t1 reload", v, 16'hFFFE);
    check("R7 t1 irq one cycle", irq1_seen - b, 1);
  endtask

  task automatic t_t1_snapshot;
    logic [7:0] d;
    load_t1(16'h00FC);
    wr(4'h7, 8'h22);
    rd(4'h9, d);  check("R11 high byte while running", d, 8'h00);
    wr(4'h7, 8'h00);
    rd(4'h8, d);  check("R11 low byte is snapshot", d, 8'hFC);
    rd(4'h9, d);
    rd(4'h8, d);  check("R11 fresh snapshot after stop", d, 8'hFE);
  endtask

  task automatic t_ref;
    logic [7:0] d;
    logic [15:0] v;
    wr(4'hA, 8'h50);
    wr(4'h7, 8'h01);
    pulse(ref_clk_i, 3);
    rd(4'hA, d);  check("R4 rising ref edges", d, 8'h53);
    wr(4'h7, 8'h05);
    pulse(ref_clk_i, 2);
    wr(4'h7, 8'h00);
    rd(4'hA, d);  check("R4 falling ref edges", d, 8'h55);
    // latency: step on third rising clk edge after the input change
    wr(4'h7, 8'h01);
    ref_clk_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rd(4'hA, d);  check("R4 no step before third edge", d, 8'h55);
    rd(4'hA, d);  check("R4 step at third edge", d, 8'h56);
    ref_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    wr(4'h7, 8'h00);
    load_t1(16'h0200);
    wr(4'h7, 8'h02);
    pulse(ref_clk_i, 2);
    wr(4'h7, 8'h00);
    rd_t1(v);     check("R4 t1 rising ref edges", v, 16'h0202);
  endtask

  task automatic t_ext;
    logic [15:0] v;
    load_t1(16'h0010);
    wr(4'h7, 8'hA2);
    repeat (20) @(negedge clk_i);
    rd_t1(v);     check("R5 system select ignored in ext mode", v, 16'h0010);
    pulse(ref_clk_i, 2);
    rd_t1(v);     check("R5 ref ignored in ext mode", v, 16'h0010);
    pulse(ext_clk_i, 3);
    rd_t1(v);     check("R5 rising ext edges", v, 16'h0013);
    wr(4'h7, 8'h8A);
    pulse(ext_clk_i, 2);
    rd_t1(v);     check("R5 falling ext edges", v, 16'h0015);
    wr(4'h7, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_t0_sys();
    t_t0_ovf();
    t_freeze();
    t_t0_priority();
    t_t1_buffer();
    t_t1_count();
    t_t1_snapshot();
    t_ref();
    t_ext();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule